// File: doc/BRIEF.md
# Gated Prescaled Period Timer

A general-purpose up-counter with a programmable period. Each time the count is advanced while it already equals the period value, it returns to zero. It also raises a sticky event flag, which stays set until a one-cycle clear pulse removes it.

The count can be advanced from one of four sources:

- the internal clock, on every cycle;
- the internal clock, only while a gate level on the external pin is high;
- rising edges of the external pin, taken through a two-flop synchroniser;
- rising edges of the external pin, taken without a synchroniser, which gives the shortest latency.

Every source passes through a prescaler that divides by 1, 8, 64 or 256.

In gated mode the flag reports the falling edge of the gate rather than the period wrap. An idle input can halt counting, but only when the stop-in-idle bit is set. Software can load the count directly at any time. Turning the timer off freezes the count.

Top module: `gpt_timer`

Control word `ctrl_word` fields:

| Bits | Function |
|---|---|
| [15] | run enable |
| [13] | stop-in-idle |
| [6] | gate enable |
| [5:4] | prescale select |
| [2] | synchronise external pin |
| [1] | external source select |

## Requirements
- R1: With run=1, internal source and prescale select 0, the count increases by one on each clock edge. An advance while the count equals `period_val` loads 0 instead.
- R2: Prescale select values 0, 1, 2 and 3 make the count advance once per 1, 8, 64 and 256 source ticks respectively.
- R3: With ctrl[1]=1 and ctrl[2]=1, the count advances once per rising edge of `ext_pin`. The new value is visible after the third clock edge following the rise.
- R4: With ctrl[1]=1 and ctrl[2]=0, the count advances once per rising edge of `ext_pin`. The new value is visible after the first clock edge following the rise.
- R5: With ctrl[6]=1 and ctrl[1]=0, the count advances on clock edges while the synchronised `ext_pin` is high. A period wrap does not set the flag. The synchronised falling edge of the pin sets the flag.
- R6: With ctrl[13]=1, a high `idle_in` holds the count, and counting resumes when `idle_in` drops. With ctrl[13]=0, `idle_in` has no effect.
- R7: With run=0, the count holds its value.
- R8: `cnt_wr` loads `cnt_wdata` at the next edge and clears the prescaler, so a full prescale interval follows the write.
- R9: Outside gated mode, a period wrap sets `evt_flag`. The flag stays set until a `flag_clr` pulse clears it.
- R10: Changing `period_val` does not alter the current count.
- R11: After reset the count is 0 and the flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | active-low asynchronous reset |
| ctrl_word | input | 16 | control fields as listed above |
| period_val | input | CNT_W | wrap value |
| cnt_wr | input | 1 | load strobe for the count |
| cnt_wdata | input | CNT_W | value loaded by `cnt_wr` |
| ext_pin | input | 1 | external clock or gate |
| idle_in | input | 1 | idle request |
| flag_clr | input | 1 | one-cycle flag clear |
| count_q | output | CNT_W | current count |
| evt_flag | output | 1 | sticky event flag |

## Verification
Every internal fault becomes visible in `count_q` within a few edges of the stimulus that exposes it:

- A prescaler that fails to clear, or that divides by the wrong ratio, shifts the count by whole steps. This appears within one prescale interval.
- A wrong synchroniser depth moves the first increment after an external rise by a clock edge or more.
- A wrong wrap compare shows up as a count above the period, or as a missing return to zero, at the first match.

Faults in the flag logic show up on `evt_flag`: in gated mode a flag that is set too early appears at the first wrap, and a flag that is never set appears one edge after the synchronised gate falls.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

  typedef enum logic [1:0] {
    SRC_CORE     = 2'd0,
    SRC_GATED    = 2'd1,
    SRC_EXT_SYNC = 2'd2,
    SRC_EXT_RAW  = 2'd3
  } gpt_src_e;

  localparam int CTL_RUN   = 15;
  localparam int CTL_IDLE  = 13;
  localparam int CTL_GATE  = 6;
  localparam int CTL_PS_LO = 4;
  localparam int CTL_SYNC  = 2;
  localparam int CTL_EXT   = 1;

  // division ratio for a prescale select value
  function automatic int unsigned ps_ratio(input logic [1:0] sel);
    case (sel)
      2'd0:    ps_ratio = 1;
      2'd1:    ps_ratio = 8;
      2'd2:    ps_ratio = 64;
      default: ps_ratio = 256;
    endcase
  endfunction

  // the external source wins over the gate
  function automatic gpt_src_e pick_src(input logic gate, input logic ext, input logic sync);
    if (ext)       pick_src = sync ? SRC_EXT_SYNC : SRC_EXT_RAW;
    else if (gate) pick_src = SRC_GATED;
    else           pick_src = SRC_CORE;
  endfunction

endpackage

// File: rtl/gpt_pin_sync.sv
module gpt_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic lvl,
  output logic rise,
  output logic fall,
  output logic raw_rise
);
  localparam int LAST = STAGES - 1;

  // sh[0..LAST] synchroniser chain, sh[STAGES] previous synchronised level
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], pin};
  end

  assign lvl      = sh[LAST];
  assign rise     = sh[LAST] & ~sh[STAGES];
  assign fall     = ~sh[LAST] & sh[STAGES];
  assign raw_rise = pin & ~sh[0];
endmodule

// File: rtl/gpt_prescaler.sv
module gpt_prescaler #(
  parameter int PS_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       tick,
  input  logic [1:0] sel,
  output logic       inc
);
  import gpt_pkg::*;

  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] lim;

  assign lim = PS_W'(ps_ratio(sel) - 1);
  assign inc = tick && (pcnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (clr)  pcnt <= '0;
    else if (tick) pcnt <= (pcnt >= lim) ? '0 : pcnt + 1'b1;
  end
endmodule

// File: rtl/gpt_counter.sv
module gpt_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         inc,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic         wrap
);
  function automatic logic [W-1:0] next_count(input logic [W-1:0] c, input logic [W-1:0] p);
    next_count = (c == p) ? '0 : c + 1'b1;
  endfunction

  assign wrap = inc && !wr && (count == period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (wr)  count <= wdata;
    else if (inc) count <= next_count(count, period);
  end
endmodule

// File: rtl/gpt_timer.sv
module gpt_timer #(
  parameter int CNT_W   = 16,
  parameter int SYNC_ST = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      ctrl_word,
  input  logic [CNT_W-1:0] period_val,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_wdata,
  input  logic             ext_pin,
  input  logic             idle_in,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             evt_flag
);
  import gpt_pkg::*;

  localparam int PS_W = 8;

  logic       run, idle_stop, gated;
  logic [1:0] ps_sel;
  gpt_src_e   src;
  logic       pin_lvl, pin_rise, pin_fall, pin_raw_rise;
  logic       tick_src, count_en, tick, inc_evt, wrap_evt, gate_fall, set_evt;
  logic       unused_ctrl;

  assign run       = ctrl_word[CTL_RUN];
  assign idle_stop = ctrl_word[CTL_IDLE];
  assign ps_sel    = ctrl_word[CTL_PS_LO +: 2];
  assign src       = pick_src(ctrl_word[CTL_GATE], ctrl_word[CTL_EXT], ctrl_word[CTL_SYNC]);
  assign gated     = (src == SRC_GATED);

  assign unused_ctrl = ^{ctrl_word[14], ctrl_word[12:7], ctrl_word[3], ctrl_word[0]};

  gpt_pin_sync #(.STAGES(SYNC_ST)) u_pin (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .lvl(pin_lvl), .rise(pin_rise), .fall(pin_fall), .raw_rise(pin_raw_rise)
  );

  always_comb begin
    case (src)
      SRC_CORE:     tick_src = 1'b1;
      SRC_GATED:    tick_src = pin_lvl;
      SRC_EXT_SYNC: tick_src = pin_rise;
      default:      tick_src = pin_raw_rise;
    endcase
  end

  assign count_en = run && !(idle_in && idle_stop);
  assign tick     = count_en && tick_src;

  gpt_prescaler #(.PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .clr(!run || cnt_wr),
    .tick(tick), .sel(ps_sel), .inc(inc_evt)
  );

  gpt_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wr(cnt_wr), .wdata(cnt_wdata),
    .inc(inc_evt), .period(period_val), .count(count_q), .wrap(wrap_evt)
  );

  assign gate_fall = run && gated && pin_fall;
  assign set_evt   = gated ? gate_fall : wrap_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_flag <= 1'b0;
    else        evt_flag <= (evt_flag && !flag_clr) || set_evt;
  end
endmodule

// File: rtl/gpt_timer_chk.sv
module gpt_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             idle_in,
  input logic             idle_stop,
  input logic             gated,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] cnt_wdata,
  input logic [CNT_W-1:0] period_val,
  input logic [CNT_W-1:0] count_q,
  input logic             inc_evt,
  input logic             gate_fall,
  input logic             set_evt,
  input logic             flag_clr,
  input logic             evt_flag
);
  assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt && !cnt_wr && count_q != period_val |=> count_q == $past(count_q) + 1'b1);

  assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    inc_evt && !cnt_wr && count_q == period_val |=> count_q == '0);

  assert_gate_flag_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    gated && !evt_flag && !gate_fall |=> !evt_flag);

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run && idle_in && idle_stop && !cnt_wr |=> $stable(count_q));

  assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_wr |=> $stable(count_q));

  assert_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count_q == $past(cnt_wdata));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag && !flag_clr |=> evt_flag);

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_clr && !set_evt |=> !evt_flag);
endmodule

bind gpt_timer gpt_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .idle_in(idle_in), .idle_stop(idle_stop),
  .gated(gated), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .period_val(period_val),
  .count_q(count_q), .inc_evt(inc_evt), .gate_fall(gate_fall), .set_evt(set_evt),
  .flag_clr(flag_clr), .evt_flag(evt_flag)
);

// File: tb/gpt_timer_bench.sv
module gpt_timer_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [15:0]  ctrl_word = '0;
  logic [W-1:0] period_val = '0;
  logic         cnt_wr = 1'b0;
  logic [W-1:0] cnt_wdata = '0;
  logic         ext_pin = 1'b0;
  logic         idle_in = 1'b0;
  logic         flag_clr = 1'b0;
  logic [W-1:0] count_q;
  logic         evt_flag;

  int total = 0;
  int bad = 0;

  localparam logic [15:0] RUN  = 16'h8000;
  localparam logic [15:0] STOP = 16'h2000;
  localparam logic [15:0] GATE = 16'h0040;
  localparam logic [15:0] SYNC = 16'h0004;
  localparam logic [15:0] EXT  = 16'h0002;

  always #4 clk = ~clk;

  gpt_timer u_gpt_timer (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .period_val(period_val),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ext_pin(ext_pin), .idle_in(idle_in),
    .flag_clr(flag_clr), .count_q(count_q), .evt_flag(evt_flag)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // load a count value, clear the flag, apply a control word (called at a negedge)
  task automatic load(input logic [15:0] c, input logic [W-1:0] p, input logic [W-1:0] v);
    ctrl_word = c; period_val = p; cnt_wr = 1'b1; cnt_wdata = v; flag_clr = 1'b1;
    @(negedge clk);
    cnt_wr = 1'b0; flag_clr = 1'b0;
  endtask

  // R1/R2/R9 sweep: count after k edges is floor(k/N) mod (P+1)
  task automatic sweep(input int ps, input int p);
    int n;
    int k_end;
    n = (ps == 0) ? 1 : (ps == 1) ? 8 : (ps == 2) ? 64 : 256;
    k_end = n * (p + 1) * 2 + 3;
    load(RUN | 16'(ps << 4), W'(p), '0);
    for (int k = 1; k <= k_end; k++) begin
      edges(1);
      chk((ps == 0) ? "R1 count" : "R2 prescaled count", count_q, (k / n) % (p + 1));
      chk("R9 flag after wrap", evt_flag, ((k / n) >= p + 1) ? 1 : 0);
    end
  endtask

  task automatic pulse(input int hi, input int lo);
    ext_pin = 1'b1; edges(hi);
    ext_pin = 1'b0; edges(lo);
  endtask

  initial begin
    #(8 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [W-1:0] snap;
    edges(3);
    chk("R11 reset count", count_q, 0);
    chk("R11 reset flag", evt_flag, 0);
    rst_n = 1'b1;
    edges(2);
    chk("R7 off after reset", count_q, 0);

    // R1 / R2 / R9
    for (int ps = 0; ps < 4; ps++) begin
      sweep(ps, 0);
      sweep(ps, 3);
      sweep(ps, 5);
    end

    // R9 clear
    flag_clr = 1'b1; ctrl_word = '0; edges(1);
    flag_clr = 1'b0; edges(1);
    chk("R9 flag cleared", evt_flag, 0);

    // R8: prescaler cleared by a write
    load(RUN | 16'h0010, 16'hFFFF, '0);
    edges(5);
    cnt_wr = 1'b1; cnt_wdata = 16'd10; edges(1); cnt_wr = 1'b0;
    chk("R8 load value", count_q, 10);
    edges(7);
    chk("R8 no step before full interval", count_q, 10);
    edges(1);
    chk("R8 step after full interval", count_q, 11);

    // R3 synchronised external edges
    load(RUN | EXT | SYNC, 16'hFFFF, '0);
    ext_pin = 1'b1; edges(2);
    chk("R3 not yet after two edges", count_q, 0);
    edges(1);
    chk("R3 visible after third edge", count_q, 1);
    ext_pin = 1'b0; edges(4);
    for (int i = 0; i < 5; i++) pulse(3, 4);
    edges(4);
    chk("R3 edge count", count_q, 6);

    // R4 unsynchronised external edges
    load(RUN | EXT, 16'hFFFF, '0);
    ext_pin = 1'b1; edges(1);
    chk("R4 visible after first edge", count_q, 1);
    ext_pin = 1'b0; edges(3);
    for (int i = 0; i < 6; i++) pulse(2, 3);
    edges(2);
    chk("R4 edge count", count_q, 7);

    // R5 gated accumulation, period 3 wraps while gate high without flag
    load(RUN | GATE, 16'd3, '0);
    ext_pin = 1'b1; edges(10);
    chk("R5 no flag on wrap while gated", evt_flag, 0);
    ext_pin = 1'b0; edges(6);
    chk("R5 gated count", count_q, 10 % 4);
    chk("R5 flag on gate fall", evt_flag, 1);
    edges(4);
    chk("R5 count held with gate low", count_q, 2);

    // R6 idle with stop bit
    load(RUN | STOP, 16'hFFFF, 16'd100);
    edges(3);
    snap = count_q;
    idle_in = 1'b1; edges(10);
    chk("R6 held in idle", count_q, snap);
    idle_in = 1'b0; edges(5);
    chk("R6 resumes after idle", count_q, snap + 5);
    ctrl_word = RUN;
    snap = count_q;
    idle_in = 1'b1; edges(6);
    chk("R6 idle ignored without stop bit", count_q, snap + 6);
    idle_in = 1'b0;

    // R7 run cleared
    snap = count_q;
    ctrl_word = '0; edges(8);
    chk("R7 frozen when off", count_q, snap);
    ctrl_word = RUN; edges(2);
    chk("R7 resumes when on", count_q, snap + 2);

    // R10 period change keeps count
    load(RUN, 16'd100, 16'd20);
    edges(1);
    period_val = 16'd50; edges(1);
    chk("R10 count kept on period change", count_q, 22);
    edges(28);
    chk("R10 at new period", count_q, 50);
    edges(1);
    chk("R10 wrap at new period", count_q, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule